// File: doc/BRIEF.md
# Four-Channel KCS Mailbox Register Block

This block is the management-controller side of a four-channel Keyboard Controller Style mailbox. The local processor reaches it through a single-cycle 32-bit register bus with byte enables. A separate host-side port lets the remote host drop a byte into a channel's input register, read its output register or read its status word. Every channel has an input data word, an output data word and a status word. The handshake flags in the status word change as side effects of accesses from either side.

Control words enable each channel and its input-full interrupt. Channel 3 needs both a base enable bit and a separate gate bit. Channel 4 keeps its data words and its enable bits in a high bank of the map. The block drives one interrupt line per channel and one combined line that is high while any channel line is pending.

Top module: `kcs_mbox`

## Requirements
- R1: The local word index is the byte address bits [11:2]. Indices at or above NREG (default 72) read as 0, and local writes to them change nothing.
- R2: A local write changes only the byte lanes whose byte enable is set. A write with no byte enable set has no effect.
- R3: After reset every word reads 0, except word 0x88, which holds the strap input. All interrupt outputs are low.
- R4: A host write to a channel's input word (host_sel_i = 0) stores the byte, zero-extended. It also sets the input-full flag, which is status bit 1.
- R5: A local read of an input word returns the stored value. It clears input-full and lowers that channel's interrupt. Input words: 0x24, 0x28, 0x2C, 0x114. Status words: 0x3C, 0x40, 0x44, 0x11C.
- R6: A host input write raises the channel interrupt only when the channel is enabled and its interrupt enable is set. Enables for channels 1 to 3 are bits 5 to 7 of word 0x00. Interrupt enables for channels 1 to 3 are bits 1 to 3 of word 0x08.
- R7: Channel 3 counts as enabled only while bit 7 of word 0x00 and bit 2 of word 0x10 are both set.
- R8: Channel 4 is enabled by bit 0 of word 0x100. Its interrupt enable is bit 1 of the same word.
- R9: A local write to an output word (0x30, 0x34, 0x38, 0x118) sets output-full, which is status bit 0. A host read of that output word (host_sel_i = 1) returns the value and clears output-full.
- R10: A host write aimed at a status word (host_sel_i = 2) changes neither the status word nor the interrupts.
- R11: irq_o is high exactly while at least one bit of chan_irq_o is high.
- R12: When a local read of an input word and a host write of the same input word fall in one cycle, the host write wins. Input-full stays set, the new byte is kept, and the interrupt is not lowered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strap_i | input | 32 | Reset value for word 0x88 |
| loc_req_i | input | 1 | Local access strobe |
| loc_we_i | input | 1 | Local write (1) or read (0) |
| loc_addr_i | input | 12 | Local byte address |
| loc_be_i | input | 4 | Local byte enables |
| loc_wdata_i | input | 32 | Local write data |
| loc_rdata_o | output | 32 | Local read data, same cycle |
| host_wr_i | input | 1 | Host write strobe |
| host_rd_i | input | 1 | Host read strobe |
| host_ch_i | input | 2 | Host channel, 0 = channel 1 |
| host_sel_i | input | 2 | Host target: 0 input, 1 output, 2 status, 3 none |
| host_wdata_i | input | 8 | Host write byte |
| host_rdata_o | output | 32 | Host read data, same cycle |
| chan_irq_o | output | 4 | Per-channel interrupt |
| irq_o | output | 1 | Combined interrupt |

## Verification
A wrong input-full or output-full flag appears in the status word on the first local read after the access that caused it. A wrong interrupt state appears on chan_irq_o and irq_o at the clock edge that ends the triggering access. Enable decoding errors show only when a host byte arrives, so each enable combination is tried on its own with a fresh host write. A fault in the collision priority needs both sides active in the same cycle, so the bench drives that case directly.

// File: rtl/kcs_mbox_pkg.sv
package kcs_mbox_pkg;
  localparam int unsigned NCH = 4;
  localparam int unsigned IXW = 10;  // 0x1000-byte window, word index

  typedef enum logic [1:0] {HS_IN = 2'd0, HS_OUT = 2'd1, HS_STAT = 2'd2, HS_NONE = 2'd3} host_sel_e;

  localparam int IX_CHAN_EN = 0;   // 0x00
  localparam int IX_IRQ_EN  = 2;   // 0x08
  localparam int IX_GATE    = 4;   // 0x10
  localparam int IX_STRAP   = 34;  // 0x88
  localparam int IX_HI_CTL  = 64;  // 0x100

  localparam int EN_LSB    = 5;
  localparam int IE_LSB    = 1;
  localparam int GATE_BIT  = 2;
  localparam int HI_EN_BIT = 0;
  localparam int HI_IE_BIT = 1;

  localparam int ST_OBF = 0;
  localparam int ST_IBF = 1;

  function automatic logic [IXW-1:0] in_ix(logic [1:0] ch);
    return (ch == 2'd3) ? IXW'(69) : IXW'(9) + IXW'(ch);
  endfunction

  function automatic logic [IXW-1:0] out_ix(logic [1:0] ch);
    return (ch == 2'd3) ? IXW'(70) : IXW'(12) + IXW'(ch);
  endfunction

  function automatic logic [IXW-1:0] st_ix(logic [1:0] ch);
    return (ch == 2'd3) ? IXW'(71) : IXW'(15) + IXW'(ch);
  endfunction
endpackage

// File: rtl/kcs_regfile.sv
module kcs_regfile
  import kcs_mbox_pkg::*;
#(
  parameter int unsigned NREG = 72,
  parameter int unsigned DW   = 32,
  localparam int unsigned AW  = $clog2(NREG),
  localparam int unsigned NBE = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] strap_i,
  input  logic          l_we_i,
  input  logic [AW-1:0] l_ix_i,
  input  logic [NBE-1:0] l_be_i,
  input  logic [DW-1:0] l_wdata_i,
  input  logic          h_we_i,
  input  logic [AW-1:0] h_ix_i,
  input  logic [DW-1:0] h_wdata_i,
  output logic [DW-1:0] regs_o [NREG]
);
  for (genvar i = 0; i < NREG; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_o[i] <= (i == IX_STRAP) ? strap_i : '0;
      end else if (h_we_i && h_ix_i == AW'(i)) begin
        regs_o[i] <= h_wdata_i;  // host side wins a same-word collision
      end else if (l_we_i && l_ix_i == AW'(i)) begin
        for (int b = 0; b < NBE; b++)
          if (l_be_i[b]) regs_o[i][8*b +: 8] <= l_wdata_i[8*b +: 8];
      end
    end
  end
endmodule

// File: rtl/kcs_chan.sv
module kcs_chan (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       host_in_wr_i,
  input  logic       loc_in_rd_i,
  input  logic       loc_out_wr_i,
  input  logic       host_out_rd_i,
  input  logic       loc_st_wr_i,
  input  logic [1:0] st_wdata_i,
  input  logic       en_i,
  input  logic       ie_i,
  output logic       ibf_o,
  output logic       obf_o,
  output logic       irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ibf_o <= 1'b0;
      obf_o <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      if (host_in_wr_i)      ibf_o <= 1'b1;
      else if (loc_st_wr_i)  ibf_o <= st_wdata_i[1];
      else if (loc_in_rd_i)  ibf_o <= 1'b0;

      if (loc_out_wr_i)       obf_o <= 1'b1;
      else if (loc_st_wr_i)   obf_o <= st_wdata_i[0];
      else if (host_out_rd_i) obf_o <= 1'b0;

      if (host_in_wr_i) begin
        if (en_i && ie_i) irq_o <= 1'b1;
      end else if (loc_in_rd_i && ibf_o) begin
        irq_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/kcs_mbox.sv
module kcs_mbox
  import kcs_mbox_pkg::*;
#(
  parameter int unsigned NREG = 72,
  parameter int unsigned HDW  = 8,
  localparam int unsigned DW  = 32,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [DW-1:0]  strap_i,
  input  logic           loc_req_i,
  input  logic           loc_we_i,
  input  logic [11:0]    loc_addr_i,
  input  logic [3:0]     loc_be_i,
  input  logic [DW-1:0]  loc_wdata_i,
  output logic [DW-1:0]  loc_rdata_o,
  input  logic           host_wr_i,
  input  logic           host_rd_i,
  input  logic [1:0]     host_ch_i,
  input  logic [1:0]     host_sel_i,
  input  logic [HDW-1:0] host_wdata_i,
  output logic [DW-1:0]  host_rdata_o,
  output logic [NCH-1:0] chan_irq_o,
  output logic           irq_o
);
  logic [DW-1:0]  regs [NREG];
  logic [IXW-1:0] loc_ix;
  logic           loc_in_range, loc_wr, loc_rd;
  logic [AW-1:0]  h_in_ix, h_out_ix, h_st_ix, h_ix;
  logic           h_we;
  logic [NCH-1:0] host_in_wr, host_out_rd, loc_in_rd, loc_out_wr, loc_st_wr;
  logic [NCH-1:0] chan_en, chan_ie, ibf_q, obf_q;

  assign loc_ix       = loc_addr_i[11:2];
  assign loc_in_range = loc_ix < IXW'(NREG);
  assign loc_wr       = loc_req_i && loc_we_i && loc_in_range && (|loc_be_i);
  assign loc_rd       = loc_req_i && !loc_we_i && loc_in_range;

  assign h_in_ix  = AW'(in_ix(host_ch_i));
  assign h_out_ix = AW'(out_ix(host_ch_i));
  assign h_st_ix  = AW'(st_ix(host_ch_i));
  assign h_we     = host_wr_i && (host_sel_i == HS_IN || host_sel_i == HS_OUT);
  assign h_ix     = (host_sel_i == HS_IN) ? h_in_ix : h_out_ix;

  kcs_regfile #(.NREG(NREG), .DW(DW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strap_i   (strap_i),
    .l_we_i    (loc_wr),
    .l_ix_i    (loc_ix[AW-1:0]),
    .l_be_i    (loc_be_i),
    .l_wdata_i (loc_wdata_i),
    .h_we_i    (h_we),
    .h_ix_i    (h_ix),
    .h_wdata_i ({{(DW-HDW){1'b0}}, host_wdata_i}),
    .regs_o    (regs)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    if (c < 3) begin : g_low
      if (c == 2) begin : g_gated
        assign chan_en[c] = regs[IX_CHAN_EN][EN_LSB+c] && regs[IX_GATE][GATE_BIT];
      end else begin : g_plain
        assign chan_en[c] = regs[IX_CHAN_EN][EN_LSB+c];
      end
      assign chan_ie[c] = regs[IX_IRQ_EN][IE_LSB+c];
    end else begin : g_high
      assign chan_en[c] = regs[IX_HI_CTL][HI_EN_BIT];
      assign chan_ie[c] = regs[IX_HI_CTL][HI_IE_BIT];
    end

    assign host_in_wr[c]  = host_wr_i && host_sel_i == HS_IN  && host_ch_i == 2'(c);
    assign host_out_rd[c] = host_rd_i && host_sel_i == HS_OUT && host_ch_i == 2'(c);
    assign loc_in_rd[c]   = loc_rd && loc_ix == in_ix(2'(c));
    assign loc_out_wr[c]  = loc_wr && loc_ix == out_ix(2'(c));
    assign loc_st_wr[c]   = loc_wr && loc_be_i[0] && loc_ix == st_ix(2'(c));

    kcs_chan u_chan (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .host_in_wr_i  (host_in_wr[c]),
      .loc_in_rd_i   (loc_in_rd[c] && !host_in_wr[c]),
      .loc_out_wr_i  (loc_out_wr[c]),
      .host_out_rd_i (host_out_rd[c]),
      .loc_st_wr_i   (loc_st_wr[c]),
      .st_wdata_i    (loc_wdata_i[1:0]),
      .en_i          (chan_en[c]),
      .ie_i          (chan_ie[c]),
      .ibf_o         (ibf_q[c]),
      .obf_o         (obf_q[c]),
      .irq_o         (chan_irq_o[c])
    );
  end

  always_comb begin
    loc_rdata_o = '0;
    if (loc_in_range) begin
      loc_rdata_o = regs[loc_ix[AW-1:0]];
      for (int c = 0; c < NCH; c++)
        if (loc_ix == st_ix(2'(c))) begin
          loc_rdata_o[ST_IBF] = ibf_q[c];
          loc_rdata_o[ST_OBF] = obf_q[c];
        end
    end
  end

  always_comb begin
    host_rdata_o = '0;
    case (host_sel_i)
      HS_IN:   host_rdata_o = regs[h_in_ix];
      HS_OUT:  host_rdata_o = regs[h_out_ix];
      HS_STAT: begin
        host_rdata_o         = regs[h_st_ix];
        host_rdata_o[ST_IBF] = ibf_q[host_ch_i];
        host_rdata_o[ST_OBF] = obf_q[host_ch_i];
      end
      default: host_rdata_o = '0;
    endcase
  end

  assign irq_o = |chan_irq_o;
endmodule

// File: rtl/kcs_mbox_chk.sv
module kcs_mbox_chk #(
  parameter int unsigned NREG = 72
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        host_wr_i,
  input logic        host_rd_i,
  input logic [1:0]  host_sel_i,
  input logic [1:0]  host_ch_i,
  input logic        loc_req_i,
  input logic        loc_we_i,
  input logic [11:0] loc_addr_i,
  input logic [31:0] loc_rdata_o,
  input logic [3:0]  ibf_q,
  input logic [3:0]  obf_q,
  input logic [3:0]  chan_irq_o
);
  AST_HOST_WR_SETS_IBF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && host_sel_i == 2'd0) |=> ibf_q[$past(host_ch_i)]); // R4

  AST_IRQ_RISE_WITH_IBF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((chan_irq_o & ~$past(chan_irq_o)) != 4'd0) |-> (((chan_irq_o & ~$past(chan_irq_o)) & ~ibf_q) == 4'd0)); // R6

  AST_HOST_RD_CLEARS_OBF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rd_i && host_sel_i == 2'd1 && !loc_req_i) |=> !obf_q[$past(host_ch_i)]); // R9

  AST_IRQ_CHANGE_CAUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(chan_irq_o) |-> $past(host_wr_i || (loc_req_i && !loc_we_i))); // R5

  AST_OOR_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc_req_i && !loc_we_i && 32'(loc_addr_i[11:2]) >= NREG) |-> loc_rdata_o == 32'd0); // R1

  AST_OBF_CHANGE_CAUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(obf_q) |-> $past(host_rd_i || (loc_req_i && loc_we_i))); // R9
endmodule

bind kcs_mbox kcs_mbox_chk #(.NREG(NREG)) u_chk (.*);

// File: tb/kcs_mbox_tb.sv
module kcs_mbox_tb;
  localparam logic [31:0] STRAP = 32'hC0DE_0007;

  logic        clk = 0, rst_n = 0;
  logic        loc_req = 0, loc_we = 0;
  logic [11:0] loc_addr = '0;
  logic [3:0]  loc_be = '0;
  logic [31:0] loc_wdata = '0, loc_rdata, host_rdata;
  logic        host_wr = 0, host_rd = 0;
  logic [1:0]  host_ch = '0, host_sel = 2'd3;
  logic [7:0]  host_wdata = '0;
  logic [3:0]  chan_irq;
  logic        irq;
  int total = 0, bad = 0;
  logic done = 0;

  always #2 clk = ~clk;

  kcs_mbox u_dut (
    .clk_i(clk), .rst_ni(rst_n), .strap_i(STRAP),
    .loc_req_i(loc_req), .loc_we_i(loc_we), .loc_addr_i(loc_addr), .loc_be_i(loc_be),
    .loc_wdata_i(loc_wdata), .loc_rdata_o(loc_rdata),
    .host_wr_i(host_wr), .host_rd_i(host_rd), .host_ch_i(host_ch), .host_sel_i(host_sel),
    .host_wdata_i(host_wdata), .host_rdata_o(host_rdata),
    .chan_irq_o(chan_irq), .irq_o(irq)
  );

  // {we, addr, be, wdata, expected read}
  localparam int NV = 12;
  localparam logic [80:0] VEC [NV] = '{
    {1'b1, 12'h00C, 4'hF, 32'h1234_5678, 32'h0},
    {1'b0, 12'h00C, 4'hF, 32'h0,         32'h1234_5678},
    {1'b1, 12'h00C, 4'h4, 32'hAABB_CCDD, 32'h0},
    {1'b0, 12'h00C, 4'hF, 32'h0,         32'h12BB_5678},
    {1'b1, 12'h080, 4'h9, 32'h1122_3344, 32'h0},
    {1'b0, 12'h080, 4'hF, 32'h0,         32'h1100_0044},
    {1'b1, 12'h400, 4'hF, 32'hDEAD_BEEF, 32'h0},
    {1'b0, 12'h400, 4'hF, 32'h0,         32'h0},
    {1'b0, 12'hFFC, 4'hF, 32'h0,         32'h0},
    {1'b1, 12'h00C, 4'h0, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 12'h00C, 4'hF, 32'h0,         32'h12BB_5678},
    {1'b0, 12'h120, 4'hF, 32'h0,         32'h0}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic lwr(input logic [11:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    loc_req = 1; loc_we = 1; loc_addr = a; loc_be = be; loc_wdata = d;
    @(posedge clk); #1;
    loc_req = 0; loc_we = 0;
  endtask

  task automatic lrd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    loc_req = 1; loc_we = 0; loc_addr = a; loc_be = 4'hF;
    #1 d = loc_rdata;
    @(posedge clk); #1;
    loc_req = 0;
  endtask

  task automatic hwr(input logic [1:0] ch, input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1; host_ch = ch; host_sel = sel; host_wdata = d;
    @(posedge clk); #1;
    host_wr = 0; host_sel = 2'd3;
  endtask

  task automatic hrd(input logic [1:0] ch, input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk);
    host_rd = 1; host_ch = ch; host_sel = sel;
    #1 d = host_rdata;
    @(posedge clk); #1;
    host_rd = 0; host_sel = 2'd3;
  endtask

  task automatic irq_is(input logic [3:0] exp, input string req);
    @(negedge clk);
    chk({28'd0, chan_irq}, {28'd0, exp}, req);
    chk({31'd0, irq}, {31'd0, exp != 4'd0}, "R11 combined");
  endtask

  initial begin
    #400000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    chk({31'd0, irq}, 32'd0, "R3 irq at reset");
    chk({28'd0, chan_irq}, 32'd0, "R3 chan irq at reset");
    rst_n = 1;
    lrd(12'h088, r); chk(r, STRAP, "R3 strap word");
    lrd(12'h000, r); chk(r, 32'd0, "R3 control word");
    lrd(12'h03C, r); chk(r, 32'd0, "R3 status word");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][80]) lwr(VEC[i][79:68], VEC[i][67:64], VEC[i][63:32]);
      else begin
        lrd(VEC[i][79:68], r);
        chk(r, VEC[i][31:0], "R1/R2 vector read");
      end
    end

    // channel 1 and 2 enabled, only channel 1 interrupt enabled
    lwr(12'h000, 4'hF, 32'h60);
    lwr(12'h008, 4'hF, 32'h02);
    hwr(2'd0, 2'd0, 8'h5A);
    irq_is(4'b0001, "R6 ch1 irq");
    lrd(12'h03C, r); chk(r, 32'h2, "R4 ibf set");
    lrd(12'h024, r); chk(r, 32'h5A, "R5 input data");
    irq_is(4'b0000, "R5 irq lowered");
    lrd(12'h03C, r); chk(r, 32'h0, "R5 ibf cleared");

    hwr(2'd1, 2'd0, 8'h33);
    irq_is(4'b0000, "R6 ch2 ie off");
    lrd(12'h040, r); chk(r, 32'h2, "R4 ch2 ibf");
    lrd(12'h028, r); chk(r, 32'h33, "R5 ch2 data");

    // channel 3: base enable without gate
    lwr(12'h008, 4'hF, 32'h0A);
    lwr(12'h000, 4'hF, 32'hE0);
    hwr(2'd2, 2'd0, 8'h44);
    irq_is(4'b0000, "R7 gate off");
    lrd(12'h02C, r); chk(r, 32'h44, "R5 ch3 data");
    lwr(12'h010, 4'hF, 32'h04);
    hwr(2'd2, 2'd0, 8'h45);
    irq_is(4'b0100, "R7 gate on");
    lrd(12'h02C, r);
    irq_is(4'b0000, "R5 ch3 lowered");

    // channel 4: interrupt enable without channel enable, then both
    lwr(12'h100, 4'hF, 32'h2);
    hwr(2'd3, 2'd0, 8'h70);
    irq_is(4'b0000, "R8 ch4 disabled");
    lrd(12'h114, r);
    lwr(12'h100, 4'hF, 32'h3);
    hwr(2'd3, 2'd0, 8'h77);
    irq_is(4'b1000, "R8 ch4 irq");
    lrd(12'h11C, r); chk(r, 32'h2, "R8 ch4 status");
    lrd(12'h114, r); chk(r, 32'h77, "R8 ch4 data");
    irq_is(4'b0000, "R8 ch4 lowered");

    // output path
    lwr(12'h030, 4'hF, 32'hC3);
    lrd(12'h03C, r); chk(r, 32'h1, "R9 obf set");
    hrd(2'd0, 2'd1, r); chk(r, 32'hC3, "R9 host output data");
    lrd(12'h03C, r); chk(r, 32'h0, "R9 obf cleared");

    // host status write ignored
    hwr(2'd0, 2'd0, 8'h11);
    hwr(2'd0, 2'd2, 8'hFF);
    lrd(12'h03C, r); chk(r, 32'h2, "R10 status unchanged");
    hrd(2'd0, 2'd2, r); chk(r, 32'h2, "R10 host status view");
    irq_is(4'b0001, "R10 irq unchanged");

    // collision: local read and host write of input word 1
    @(negedge clk);
    loc_req = 1; loc_we = 0; loc_addr = 12'h024; loc_be = 4'hF;
    host_wr = 1; host_ch = 2'd0; host_sel = 2'd0; host_wdata = 8'h99;
    #1 chk(loc_rdata, 32'h11, "R12 old value read");
    @(posedge clk); #1;
    loc_req = 0; host_wr = 0; host_sel = 2'd3;
    irq_is(4'b0001, "R12 irq kept");
    lrd(12'h03C, r); chk(r, 32'h2, "R12 ibf kept");
    lrd(12'h024, r); chk(r, 32'h99, "R12 new byte");

    // combined line with two pending channels
    hwr(2'd0, 2'd0, 8'h01);
    hwr(2'd3, 2'd0, 8'h02);
    irq_is(4'b1001, "R11 two pending");
    lrd(12'h024, r);
    irq_is(4'b1000, "R11 one pending");
    lrd(12'h114, r);
    irq_is(4'b0000, "R11 none pending");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule